// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupts

This block gives software a bank of general-purpose pins behind a small 32-bit register bus. Each pin can be an input or an output. Reading the value register returns the level of each input pin and the driven level of each output pin. Writing it sets the output levels. Input pins pass through a two-flop synchronizer before any interrupt logic sees them.

Every pin can report an event, and three per-pin configuration registers choose the trigger. With the edge-select and both-edge bits clear, the pin is level sensitive and the polarity bit picks the active level. With edge-select set, it catches the rising or the falling edge, again chosen by polarity. With both-edge set, it catches every transition whatever the other two bits hold.

Events latch into a raw status register. Software clears them by writing ones to a clear register. A pending register shows the raw status masked by the per-pin enables. A single registered interrupt line reports whether any pin is pending. A read-only version register returns a build-time constant.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While and after reset: interrupt enables, raw status, edge-select, polarity, both-edge and output latches are all 0; every direction bit is 1 (input); `pin_oe` and `irq` are 0.
- R2: Direction register at byte offset 0x04. A bit of 1 makes the pin an input (`pin_oe` bit low). A bit of 0 makes it an output (`pin_oe` bit high). `pin_oe` follows from the edge that takes the write.
- R3: Value register at offset 0x00. A write sets `pin_out`. A read returns the synchronized input level for input pins and the output latch for output pins. An input change becomes readable two clock edges after it is applied.
- R4: Level mode (edge-select at 0x18 = 0, both-edge at 0x24 = 0). The raw status bit (offset 0x0C) latches while the synchronized pin equals its polarity bit (offset 0x1C; 1 = high active, 0 = low active). The bit is set on the third edge after the pin changes and stays set after the level goes away.
- R5: Edge mode (edge-select = 1, both-edge = 0). Polarity 1 latches on a rising transition only. Polarity 0 latches on a falling transition only. A steady level does not re-latch after a clear.
- R6: With the both-edge bit at 1, both transitions latch, whatever the edge-select and polarity bits hold. A steady level does not re-latch.
- R7: Writing 1 to a bit of the clear register (offset 0x14) clears that raw status bit on the write edge. Writing 0 to a bit leaves it unchanged. A clear wins over an event in the same cycle. A level-mode pin whose active level persists is set again on the following edge. The clear register reads 0.
- R8: The pending register (offset 0x10) equals raw status AND the enable register (offset 0x08). Raw status is not masked by the enables.
- R9: `irq` is the OR of all pending bits, registered. It rises or falls one edge after the pending set changes.
- R10: The version register (offset 0x20) reads the `VERSION` parameter. Writes to it change nothing.
- R11: Register bits at and above `NUM_PINS` read 0 and ignore writes. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, takes effect on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pin_in | input | NUM_PINS | Pad input levels, asynchronous |
| pin_out | output | NUM_PINS | Output latch levels |
| pin_oe | output | NUM_PINS | Output enable per pin, high for output pins |
| irq | output | 1 | Combined registered interrupt |

## Verification
The bench builds the block with `NUM_PINS = 12` and a non-default `VERSION`. Writing all ones to a register therefore shows the unused upper twenty bits reading back as zero, and the version read cannot match the default by accident. Twelve pins leave room to give separate pins to the level, edge, both-edge and masking scenarios. Four pins serve as outputs and four as inputs for the mixed value read-back.

// File: rtl/gpio_irq_pkg.sv
// Shared constants and the register decode for the GPIO interrupt controller.
// Assumes a byte-addressed bus with 32-bit aligned registers.
package gpio_irq_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_VALUE = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_EN    = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_RAW   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_PEND  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_EDGE  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_POL   = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_VER   = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_BOTH  = 8'h24;

    typedef enum logic [3:0] {
        SEL_VALUE, SEL_DIR, SEL_EN, SEL_RAW, SEL_PEND,
        SEL_CLR, SEL_EDGE, SEL_POL, SEL_VER, SEL_BOTH, SEL_NONE
    } reg_sel_e;

    // Map a byte address to a register selector.
    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_VALUE: return SEL_VALUE;
            OFS_DIR:   return SEL_DIR;
            OFS_EN:    return SEL_EN;
            OFS_RAW:   return SEL_RAW;
            OFS_PEND:  return SEL_PEND;
            OFS_CLR:   return SEL_CLR;
            OFS_EDGE:  return SEL_EDGE;
            OFS_POL:   return SEL_POL;
            OFS_VER:   return SEL_VER;
            OFS_BOTH:  return SEL_BOTH;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
// Two-flop synchronizer for a vector of asynchronous pad inputs.
// Assumes each bit is independent; no multi-bit coherence is offered.
module gpio_pin_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Capture the pads, then re-time once more to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_trig_detect.sv
// Per-pin trigger detection and raw event latch.
// Assumes sync_in is already synchronous. The clear vector is valid for one
// cycle, and a clear wins over an event arriving in the same cycle.
module gpio_trig_detect #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] sync_in,
    input  logic [NUM_PINS-1:0] edge_sel,
    input  logic [NUM_PINS-1:0] pol,
    input  logic [NUM_PINS-1:0] both,
    input  logic [NUM_PINS-1:0] clr,
    output logic [NUM_PINS-1:0] raw
);

    logic [NUM_PINS-1:0] prev_q;
    logic [NUM_PINS-1:0] evt;
    logic [NUM_PINS-1:0] raw_q;

    // Keep last cycle's sample for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_in;
    end

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
            logic rise;
            logic fall;
            assign rise = sync_in[i] & ~prev_q[i];
            assign fall = ~sync_in[i] & prev_q[i];
            // Both-edge overrides; otherwise edge or level chosen by edge_sel.
            assign evt[i] = both[i]     ? (rise | fall) :
                            edge_sel[i] ? (pol[i] ? rise : fall) :
                                          ~(sync_in[i] ^ pol[i]);

            // R4 R5 R6: a raw bit only rises when its trigger fired the cycle before.
            a_r5_latch_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(raw_q[i]) |-> $past(evt[i]));
        end
    endgenerate

    // Accumulate events; write-one-to-clear takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q | evt) & ~clr;
    end

    assign raw = raw_q;

    // R7: every bit named in a clear is zero on the following cycle.
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr) |=> ((raw_q & $past(clr)) == '0));

endmodule

// File: rtl/gpio_irq_merge.sv
// Masks raw events with the enables and registers the combined interrupt.
// Assumes raw and en are synchronous to clk.
module gpio_irq_merge #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] raw,
    input  logic [NUM_PINS-1:0] en,
    output logic [NUM_PINS-1:0] pending,
    output logic                irq
);

    logic irq_q;

    assign pending = raw & en;

    // Register the OR of all pending bits to give a glitch-free line.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |pending;
    end

    assign irq = irq_q;

    // R9: with every enable off, the line is low on the next cycle.
    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |=> !irq_q);

endmodule

// File: rtl/gpio_irq_ctrl.sv
// GPIO controller top: register bank, read mux, pin synchronizer, trigger
// detection and interrupt merge. Assumes NUM_PINS <= 32, a single-cycle write
// strobe and combinational reads.
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int          NUM_PINS = 32,
    parameter logic [31:0] VERSION  = 32'h0001_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);

    localparam int N = NUM_PINS;

    reg_sel_e     sel;
    logic [N-1:0] wr_bits;
    logic [N-1:0] dir_q, out_q, en_q, edge_q, pol_q, both_q;
    logic [N-1:0] sync_in, raw, pending, clr_vec, value_rd;

    assign sel     = decode_addr(bus_addr);
    assign wr_bits = bus_wdata[N-1:0];
    assign clr_vec = (bus_wr && sel == SEL_CLR) ? wr_bits : '0;

    // Configuration registers, written by address on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '1;
            out_q  <= '0;
            en_q   <= '0;
            edge_q <= '0;
            pol_q  <= '0;
            both_q <= '0;
        end else if (bus_wr) begin
            case (sel)
                SEL_VALUE: out_q  <= wr_bits;
                SEL_DIR:   dir_q  <= wr_bits;
                SEL_EN:    en_q   <= wr_bits;
                SEL_EDGE:  edge_q <= wr_bits;
                SEL_POL:   pol_q  <= wr_bits;
                SEL_BOTH:  both_q <= wr_bits;
                default:   ;
            endcase
        end
    end

    gpio_pin_sync #(.WIDTH(N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (sync_in)
    );

    gpio_trig_detect #(.NUM_PINS(N)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (sync_in),
        .edge_sel (edge_q),
        .pol      (pol_q),
        .both     (both_q),
        .clr      (clr_vec),
        .raw      (raw)
    );

    gpio_irq_merge #(.NUM_PINS(N)) u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw     (raw),
        .en      (en_q),
        .pending (pending),
        .irq     (irq)
    );

    assign value_rd = (sync_in & dir_q) | (out_q & ~dir_q);

    // Read mux; unused upper bits and unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_VALUE: bus_rdata = DATA_W'(value_rd);
            SEL_DIR:   bus_rdata = DATA_W'(dir_q);
            SEL_EN:    bus_rdata = DATA_W'(en_q);
            SEL_RAW:   bus_rdata = DATA_W'(raw);
            SEL_PEND:  bus_rdata = DATA_W'(pending);
            SEL_EDGE:  bus_rdata = DATA_W'(edge_q);
            SEL_POL:   bus_rdata = DATA_W'(pol_q);
            SEL_BOTH:  bus_rdata = DATA_W'(both_q);
            SEL_VER:   bus_rdata = VERSION;
            default:   bus_rdata = '0;
        endcase
    end

    assign pin_out = out_q;
    assign pin_oe  = ~dir_q;

    // R2: a direction write shows on the output enables after its edge.
    a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_DIR) |=> (pin_oe == ~$past(wr_bits)));

endmodule

// File: tb/gpio_irq_ctrl_test.sv
`timescale 1ns/100ps
module gpio_irq_ctrl_test;

    localparam int          NP  = 12;
    localparam logic [31:0] VER = 32'h0003_0102;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic          irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_irq_ctrl #(.NUM_PINS(NP), .VERSION(VER)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #0.1;
        v = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        tick(3);
        rd(8'h04, v); chk("R1 dir", v, 32'h0000_0FFF);
        rd(8'h08, v); chk("R1 en", v, 0);
        rd(8'h0C, v); chk("R1 raw", v, 0);
        rd(8'h18, v); chk("R1 edge", v, 0);
        rd(8'h1C, v); chk("R1 pol", v, 0);
        rd(8'h24, v); chk("R1 both", v, 0);
        chk("R1 pin_oe", 32'(pin_oe), 0);
        chk("R1 pin_out", 32'(pin_out), 0);
        chk("R1 irq", 32'(irq), 0);
        rst_n = 1'b1;
        tick(1);
        wr(8'h1C, 32'hFFF);
        tick(3);
        wr(8'h14, 32'hFFF);
        tick(1);
        rd(8'h0C, v); chk("R1 raw quiet after setup", v, 0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        pin_in[0] = 1'b1; tick(3);
        rd(8'h0C, v); chk("R4 level high latch", v & 1, 1);
        pin_in[0] = 1'b0; tick(3);
        rd(8'h0C, v); chk("R4 stays latched", v & 1, 1);
        wr(8'h14, 32'h0);
        rd(8'h0C, v); chk("R7 zero write no effect", v & 1, 1);
        wr(8'h14, 32'h1);
        rd(8'h0C, v); chk("R7 clear", v & 1, 0);
        tick(1);
        rd(8'h0C, v); chk("R4 inactive level no relatch", v & 1, 0);
        wr(8'h1C, 32'hFFE);
        tick(1);
        rd(8'h0C, v); chk("R4 level low latch", v & 1, 1);
        wr(8'h14, 32'h1);
        rd(8'h0C, v); chk("R7 clear wins", v & 1, 0);
        tick(1);
        rd(8'h0C, v); chk("R7 level relatch next cycle", v & 1, 1);
        wr(8'h1C, 32'hFFF);
        wr(8'h14, 32'h1);
        tick(1);
        rd(8'h0C, v); chk("R4 restored quiet", v & 1, 0);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        wr(8'h18, 32'h002);
        wr(8'h14, 32'h002);
        pin_in[1] = 1'b1; tick(3);
        rd(8'h0C, v); chk("R5 rising latch", v & 2, 2);
        wr(8'h14, 32'h002); tick(3);
        rd(8'h0C, v); chk("R5 steady high no relatch", v & 2, 0);
        pin_in[1] = 1'b0; tick(3);
        rd(8'h0C, v); chk("R5 falling ignored when rising", v & 2, 0);
        wr(8'h1C, 32'hFFD);
        pin_in[1] = 1'b1; tick(3);
        rd(8'h0C, v); chk("R5 rising ignored when falling", v & 2, 0);
        pin_in[1] = 1'b0; tick(3);
        rd(8'h0C, v); chk("R5 falling latch", v & 2, 2);
        wr(8'h14, 32'h002);
    endtask

    task automatic t_both();
        logic [31:0] v;
        wr(8'h24, 32'h004);
        wr(8'h1C, 32'hFF9);
        wr(8'h14, 32'h004);
        pin_in[2] = 1'b1; tick(3);
        rd(8'h0C, v); chk("R6 rise latches", v & 4, 4);
        wr(8'h14, 32'h004); tick(3);
        rd(8'h0C, v); chk("R6 steady no relatch", v & 4, 0);
        pin_in[2] = 1'b0; tick(3);
        rd(8'h0C, v); chk("R6 fall latches", v & 4, 4);
        wr(8'h14, 32'h004);
    endtask

    task automatic t_mask_irq();
        logic [31:0] v;
        wr(8'h1C, 32'hFF9);
        pin_in[3] = 1'b1; tick(3);
        rd(8'h0C, v); chk("R8 raw unmasked", v & 8, 8);
        rd(8'h10, v); chk("R8 pending masked", v, 0);
        chk("R9 irq low when masked", 32'(irq), 0);
        wr(8'h08, 32'h008);
        rd(8'h10, v); chk("R8 pending enabled", v, 32'h008);
        chk("R9 irq one cycle later", 32'(irq), 0);
        tick(1);
        chk("R9 irq high", 32'(irq), 1);
        wr(8'h08, 32'h0);
        chk("R9 irq still registered", 32'(irq), 1);
        tick(1);
        chk("R9 irq drops on disable", 32'(irq), 0);
        wr(8'h08, 32'h008);
        pin_in[3] = 1'b0;
        tick(3);
        wr(8'h14, 32'h008);
        tick(1);
        chk("R9 irq drops after clear", 32'(irq), 0);
        wr(8'h08, 32'h0);
    endtask

    task automatic t_value();
        logic [31:0] v;
        wr(8'h04, 32'h0FF);
        chk("R2 oe outputs", 32'(pin_oe), 32'hF00);
        rd(8'h04, v); chk("R2 dir readback", v, 32'h0FF);
        wr(8'h00, 32'hA5A);
        chk("R3 pin_out", 32'(pin_out), 32'hA5A);
        pin_in[7:4] = 4'b0110;
        tick(2);
        rd(8'h00, v); chk("R3 mixed value read", v, 32'hA60);
        wr(8'h04, 32'hFFF);
        chk("R2 oe all inputs", 32'(pin_oe), 0);
        pin_in[7:4] = 4'b0000;
    endtask

    task automatic t_misc();
        logic [31:0] v;
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, v); chk("R11 upper bits zero", v, 32'h0000_0FFF);
        wr(8'h08, 32'h0);
        rd(8'h28, v); chk("R11 unmapped 0x28", v, 0);
        rd(8'hFC, v); chk("R11 unmapped 0xFC", v, 0);
        rd(8'h14, v); chk("R7 clear reads zero", v, 0);
        rd(8'h20, v); chk("R10 version", v, VER);
        wr(8'h20, 32'hDEAD_BEEF);
        rd(8'h20, v); chk("R10 version write ignored", v, VER);
    endtask

    initial begin
        t_reset();
        t_level();
        t_edge();
        t_both();
        t_mask_irq();
        t_value();
        t_misc();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog got=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule